// File: doc/BRIEF.md
# I2C Target with Word-Accessed Receive and Transmit Files

This block is an I2C target that answers at one fixed 7-bit device address. Bytes the controller writes land in a 64-byte receive file; bytes the controller reads come from a separate 64-byte transmit file. Local software reaches both files only as whole 32-bit words. It tracks progress through two hardware pointers: a byte pointer for received data and a bit pointer for transmitted data.

The I2C pins are open-drain. The block samples SCL and SDA through synchronizers, runs on the system clock and never holds SCL low. Three interrupt causes are latched in a status register: a read has started, a read has ended, and a write has ended. Software clears them by writing ones, and each can be masked.

Local map (word addresses on `bus_addr`):
- 0x00-0x0F: receive file, read only.
- 0x10-0x1F: transmit file, read/write.
- 0x20: write pointer.
- 0x21: read pointer.
- 0x22: interrupt enable.
- 0x23: interrupt status.

Top module: `i2c_dual_file_target`

## Requirements
- R1: The target acknowledges only the address byte 0x50 followed by the R/W bit (0xA0 for a write, 0xA1 for a read). Any other address gets no acknowledge, and the transaction leaves the files, pointers and status untouched until the next START or STOP.
- R2: Receive byte p is stored in receive-file word p/4, in bits 8*(p mod 4)+7 down to 8*(p mod 4). Word w of the receive file reads on the local bus at word address w (0x00 to 0x0F).
- R3: The write pointer (bits 5:0 at word address 0x20) counts up by one for each received data byte and wraps from 63 to 0.
- R4: Every data byte written to the target is acknowledged.
- R5: In a read, the target shifts out MSB first the transmit-file byte indexed by the read pointer's byte field. The transmit file uses the same lane order as R2, and its word w is written and read at local word address 0x10+w.
- R6: The read pointer (word address 0x21) counts transmitted bits. Bits 8:3 hold the byte index and bits 2:0 the bit within the byte. It rises by one on every SCL high phase of a data bit and is unchanged by acknowledge bits.
- R7: An acknowledge from the controller after a byte starts the next byte. A not-acknowledge ends the transfer, releases SDA and sets status bit 1 (read end).
- R8: Acknowledging the target's own address with the read bit set sets status bit 0 (read start).
- R9: A STOP or repeated START that closes a write transaction addressed to this target sets status bit 2 (write end). This holds even when the transaction carried only the address byte.
- R10: Output `irq` is high exactly when some status bit and its enable bit, held in bits 2:0 at word address 0x22, are both 1.
- R11: Writing a 1 to a status bit at word address 0x23 clears that bit, and writing a 0 leaves the bit as it was.
- R12: Any local write to word address 0x20 clears the write pointer, and any local write to 0x21 clears the read pointer.
- R13: After reset the pointers, the enables, the status and both files are zero, and neither SDA nor SCL is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (always 0) |
| sda_oe | output | 1 | Pull SDA low |
| bus_sel | input | 1 | Local access strobe |
| bus_we | input | 1 | Local access is a write |
| bus_addr | input | 6 | Local word address |
| bus_wdata | input | 32 | Local write data |
| bus_rdata | output | 32 | Local read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the controller changes SDA only while SCL is low, except when it signals START or STOP. They also assume each SCL level lasts several system clocks, so that no edge is lost in the synchronizers. The bench drives every SCL phase for ten system clocks. It changes its own SDA drive only after SCL has been low for that long, and it releases SDA before each bit the target returns. As a result, every START or STOP the design sees is one the bench meant to send.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [2:0] {
    LS_IDLE, LS_ADDR, LS_ADDR_ACK, LS_WR_DATA, LS_WR_ACK, LS_RD_DATA, LS_RD_ACK, LS_PARK
  } link_state_e;
  localparam int IRQ_N = 3;  // bit0 read start, bit1 read end, bit2 write end
endpackage

// File: rtl/i2ct_bus_sense.sv
module i2ct_bus_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_lvl
);
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end
  end

  assign scl_rise  = scl_sy[1] & ~scl_q;
  assign scl_fall  = ~scl_sy[1] & scl_q;
  assign start_det = scl_sy[1] & scl_q & sda_q & ~sda_sy[1];
  assign stop_det  = scl_sy[1] & scl_q & ~sda_q & sda_sy[1];
  assign sda_lvl   = sda_sy[1];
endmodule

// File: rtl/i2ct_rx_file.sv
module i2ct_rx_file #(
  parameter int BYTES = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       byte_we,
  input  logic [$clog2(BYTES)-1:0]   byte_idx,
  input  logic [7:0]                 byte_data,
  input  logic [$clog2(BYTES)-3:0]   rd_word_idx,
  output logic [31:0]                rd_word
);
  localparam int BAW = $clog2(BYTES);
  logic [7:0] mem [BYTES];

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 mem[b] <= 8'h00;
      else if (byte_we && byte_idx == BAW'(b))    mem[b] <= byte_data;
    end
  end

  assign rd_word = {mem[{rd_word_idx, 2'd3}], mem[{rd_word_idx, 2'd2}],
                    mem[{rd_word_idx, 2'd1}], mem[{rd_word_idx, 2'd0}]};
endmodule

// File: rtl/i2ct_tx_file.sv
module i2ct_tx_file #(
  parameter int BYTES = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       word_we,
  input  logic [$clog2(BYTES)-3:0]   word_idx,
  input  logic [31:0]                word_data,
  output logic [31:0]                rd_word,
  input  logic [$clog2(BYTES)-1:0]   rd_byte_idx,
  output logic [7:0]                 rd_byte
);
  localparam int WAW = $clog2(BYTES) - 2;
  logic [7:0] mem [BYTES];

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    mem[b] <= 8'h00;
      else if (word_we && word_idx == WAW'(b / 4))   mem[b] <= word_data[8*(b%4) +: 8];
    end
  end

  assign rd_word = {mem[{word_idx, 2'd3}], mem[{word_idx, 2'd2}],
                    mem[{word_idx, 2'd1}], mem[{word_idx, 2'd0}]};
  assign rd_byte = mem[rd_byte_idx];
endmodule

// File: rtl/i2ct_link.sv
module i2ct_link import i2ct_pkg::*; #(
  parameter int          BAW      = 6,
  parameter logic [6:0]  DEV_ADDR = 7'h50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_lvl,
  input  logic [7:0]       tx_byte,
  input  logic             clr_wr_ptr,
  input  logic             clr_rd_ptr,
  output logic             sda_drv,
  output logic             rx_we,
  output logic [7:0]       rx_data,
  output logic [BAW-1:0]   wr_ptr,
  output logic [BAW+2:0]   rd_ptr,
  output logic             ev_rd_start,
  output logic             ev_rd_end,
  output logic             ev_wr_end
);
  link_state_e      st_q, st_n;
  logic [3:0]       cnt_q, cnt_n;
  logic [7:0]       sh_q, sh_n;
  logic             drv_n, isrd_q, isrd_n, wact_q, wact_n;
  logic [BAW-1:0]   wp_n;
  logic [BAW+2:0]   rp_n;
  logic             tx_bit;

  assign tx_bit  = tx_byte[3'd7 - rd_ptr[2:0]];
  assign rx_data = sh_q;

  always_comb begin
    st_n = st_q;  cnt_n = cnt_q;  sh_n = sh_q;  drv_n = sda_drv;
    isrd_n = isrd_q;  wact_n = wact_q;  wp_n = wr_ptr;  rp_n = rd_ptr;
    rx_we = 1'b0;  ev_rd_start = 1'b0;  ev_rd_end = 1'b0;  ev_wr_end = 1'b0;
    if (start_det || stop_det) begin
      ev_wr_end = wact_q;
      wact_n    = 1'b0;
      drv_n     = 1'b0;
      cnt_n     = 4'd0;
      st_n      = start_det ? LS_ADDR : LS_IDLE;
    end else begin
      unique case (st_q)
        LS_ADDR: begin
          if (scl_rise) begin
            sh_n = {sh_q[6:0], sda_lvl};  cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (sh_q[7:1] == DEV_ADDR) begin
              drv_n = 1'b1;  isrd_n = sh_q[0];  wact_n = ~sh_q[0];
              ev_rd_start = sh_q[0];  st_n = LS_ADDR_ACK;
            end else begin
              st_n = LS_PARK;
            end
          end
        end
        LS_ADDR_ACK: if (scl_fall) begin
          cnt_n = 4'd0;
          drv_n = isrd_q ? ~tx_bit : 1'b0;
          st_n  = isrd_q ? LS_RD_DATA : LS_WR_DATA;
        end
        LS_WR_DATA: begin
          if (scl_rise) begin
            sh_n = {sh_q[6:0], sda_lvl};  cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            rx_we = 1'b1;  wp_n = wr_ptr + 1'b1;  drv_n = 1'b1;  st_n = LS_WR_ACK;
          end
        end
        LS_WR_ACK: if (scl_fall) begin
          drv_n = 1'b0;  cnt_n = 4'd0;  st_n = LS_WR_DATA;
        end
        LS_RD_DATA: begin
          if (scl_rise) begin
            rp_n = rd_ptr + 1'b1;  cnt_n = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              drv_n = 1'b0;  st_n = LS_RD_ACK;
            end else begin
              drv_n = ~tx_bit;
            end
          end
        end
        LS_RD_ACK: begin
          if (scl_rise && sda_lvl) begin
            ev_rd_end = 1'b1;  st_n = LS_PARK;
          end else if (scl_fall) begin
            cnt_n = 4'd0;  drv_n = ~tx_bit;  st_n = LS_RD_DATA;
          end
        end
        default: ;
      endcase
    end
    if (clr_wr_ptr) wp_n = '0;
    if (clr_rd_ptr) rp_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LS_IDLE;  cnt_q <= 4'd0;  sh_q <= 8'h00;  sda_drv <= 1'b0;
      isrd_q <= 1'b0;  wact_q <= 1'b0;  wr_ptr <= '0;  rd_ptr <= '0;
    end else begin
      st_q <= st_n;  cnt_q <= cnt_n;  sh_q <= sh_n;  sda_drv <= drv_n;
      isrd_q <= isrd_n;  wact_q <= wact_n;  wr_ptr <= wp_n;  rd_ptr <= rp_n;
    end
  end
endmodule

// File: rtl/i2c_dual_file_target.sv
module i2c_dual_file_target import i2ct_pkg::*; #(
  parameter int          FILE_BYTES = 64,
  parameter logic [6:0]  DEV_ADDR   = 7'h50
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            scl_i,
  input  logic                            sda_i,
  output logic                            scl_oe,
  output logic                            sda_oe,
  input  logic                            bus_sel,
  input  logic                            bus_we,
  input  logic [$clog2(FILE_BYTES)-1:0]   bus_addr,
  input  logic [31:0]                     bus_wdata,
  output logic [31:0]                     bus_rdata,
  output logic                            irq
);
  localparam int BAW = $clog2(FILE_BYTES);
  localparam int WAW = BAW - 2;
  localparam int PW  = BAW + 3;

  logic [1:0]        rst_sy;
  logic              rst_q_n;
  logic              scl_rise, scl_fall, start_det, stop_det, sda_lvl;
  logic              rx_we, ev_rd_start, ev_rd_end, ev_wr_end;
  logic [7:0]        rx_data, tx_byte;
  logic [BAW-1:0]    wr_ptr;
  logic [PW-1:0]     rd_ptr;
  logic [31:0]       rx_word, tx_word;
  logic [1:0]        region;
  logic [WAW-1:0]    widx;
  logic              wen, ctrl_hit, tx_we, clr_wr, clr_rd, en_wr, st_wr;
  logic [IRQ_N-1:0]  irq_en, irq_en_n, irq_st, irq_st_n, ev_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sy <= 2'b00;
    else        rst_sy <= {rst_sy[0], 1'b1};
  end
  assign rst_q_n = rst_sy[1];

  assign region   = bus_addr[BAW-1:BAW-2];
  assign widx     = bus_addr[WAW-1:0];
  assign wen      = bus_sel & bus_we;
  assign ctrl_hit = wen && region == 2'b10 && (widx >> 2) == '0;
  assign tx_we    = wen && region == 2'b01;
  assign clr_wr   = ctrl_hit && widx[1:0] == 2'd0;
  assign clr_rd   = ctrl_hit && widx[1:0] == 2'd1;
  assign en_wr    = ctrl_hit && widx[1:0] == 2'd2;
  assign st_wr    = ctrl_hit && widx[1:0] == 2'd3;
  assign ev_vec   = {ev_wr_end, ev_rd_end, ev_rd_start};

  i2ct_bus_sense u_sense (
    .clk(clk), .rst_n(rst_q_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_lvl(sda_lvl)
  );

  i2ct_link #(.BAW(BAW), .DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_q_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl),
    .tx_byte(tx_byte), .clr_wr_ptr(clr_wr), .clr_rd_ptr(clr_rd),
    .sda_drv(sda_oe), .rx_we(rx_we), .rx_data(rx_data), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .ev_rd_start(ev_rd_start), .ev_rd_end(ev_rd_end),
    .ev_wr_end(ev_wr_end)
  );

  i2ct_rx_file #(.BYTES(FILE_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_q_n), .byte_we(rx_we), .byte_idx(wr_ptr),
    .byte_data(rx_data), .rd_word_idx(widx), .rd_word(rx_word)
  );

  i2ct_tx_file #(.BYTES(FILE_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_q_n), .word_we(tx_we), .word_idx(widx),
    .word_data(bus_wdata), .rd_word(tx_word), .rd_byte_idx(rd_ptr[PW-1:3]),
    .rd_byte(tx_byte)
  );

  always_comb begin
    irq_en_n = irq_en;
    irq_st_n = irq_st;
    if (en_wr) irq_en_n = bus_wdata[IRQ_N-1:0];
    if (st_wr) irq_st_n = irq_st_n & ~bus_wdata[IRQ_N-1:0];
    irq_st_n = irq_st_n | ev_vec;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      irq_en <= '0;
      irq_st <= '0;
    end else begin
      irq_en <= irq_en_n;
      irq_st <= irq_st_n;
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    unique case (region)
      2'b00: bus_rdata = rx_word;
      2'b01: bus_rdata = tx_word;
      2'b10: if ((widx >> 2) == '0) begin
        unique case (widx[1:0])
          2'd0: bus_rdata = {{(32-BAW){1'b0}}, wr_ptr};
          2'd1: bus_rdata = {{(32-PW){1'b0}}, rd_ptr};
          2'd2: bus_rdata = {{(32-IRQ_N){1'b0}}, irq_en};
          default: bus_rdata = {{(32-IRQ_N){1'b0}}, irq_st};
        endcase
      end
      default: bus_rdata = 32'h0;
    endcase
  end

  assign irq    = |(irq_st & irq_en);
  assign scl_oe = 1'b0;
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker #(
  parameter int BAW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stop_det,
  input logic            sda_oe,
  input logic            rx_we,
  input logic            clr_wr,
  input logic [BAW-1:0]  wr_ptr,
  input logic [BAW+2:0]  rd_ptr,
  input logic [2:0]      irq_st,
  input logic [2:0]      ev_vec,
  input logic            st_wr,
  input logic [31:0]     bus_wdata
);
  AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_we && !clr_wr) |=> $stable(wr_ptr));  // R3
  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_we && !clr_wr) |=> wr_ptr == $past(wr_ptr) + 1'b1);  // R3
  AST_RPTR_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_ptr) |-> (rd_ptr == $past(rd_ptr) + 1'b1 || rd_ptr == '0));  // R6
  AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec != 3'b0) |=> (irq_st & $past(ev_vec)) == $past(ev_vec));  // R8
  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> (irq_st & $past(bus_wdata[2:0] & ~ev_vec)) == 3'b0);  // R11
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);  // R7
endmodule

bind i2c_dual_file_target i2ct_checker #(.BAW(BAW)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .stop_det(stop_det), .sda_oe(sda_oe),
  .rx_we(rx_we), .clr_wr(clr_wr), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .irq_st(irq_st), .ev_vec(ev_vec), .st_wr(st_wr), .bus_wdata(bus_wdata)
);

// File: tb/test_i2c_dual_file_target.sv
`timescale 1ns/1ps
module test_i2c_dual_file_target;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_scl, host_sda_low;
  logic        scl_oe, sda_oe, irq;
  logic        bus_sel, bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        sda_line;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  logic [31:0] exp_q[$], act_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;
  assign sda_line = ~(host_sda_low | sda_oe);

  i2c_dual_file_target i_i2c_dual_file_target (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // driver side: push expected and observed items
  task automatic observe(input string req, input logic [31:0] e, input logic [31:0] a);
    tag_q.push_back(req);
    exp_q.push_back(e);
    act_q.push_back(a);
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      automatic string       t = tag_q.pop_front();
      automatic logic [31:0] e = exp_q.pop_front();
      automatic logic [31:0] a = act_q.pop_front();
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic reg_check(input string req, input logic [5:0] a, input logic [31:0] e);
    @(negedge clk);
    bus_addr = a;
    #1;
    observe(req, e, bus_rdata);
  endtask

  task automatic i2c_start();
    host_sda_low = 1'b0; wq(); host_scl = 1'b1; wq();
    host_sda_low = 1'b1; wq(); host_scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    host_sda_low = 1'b1; wq(); host_scl = 1'b1; wq();
    host_sda_low = 1'b0; wq(); wq();
  endtask

  task automatic send_bit(input logic b);
    host_sda_low = ~b; wq(); host_scl = 1'b1; wq(); host_scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    host_sda_low = 1'b0; wq(); host_scl = 1'b1;
    repeat (Q/2) @(negedge clk);
    b = sda_line;
    repeat (Q/2) @(negedge clk);
    host_scl = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic acked);
    logic ab;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(ab);
    acked = ~ab;
  endtask

  task automatic rd_byte(input logic ack_it, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~ack_it);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic       ak;
    logic [7:0] d;
    int         nak;
    rst_n = 1'b0; host_scl = 1'b1; host_sda_low = 1'b0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R13 reset state
    reg_check("R13 wr_ptr", 6'h20, 32'h0);
    reg_check("R13 rd_ptr", 6'h21, 32'h0);
    reg_check("R13 enable", 6'h22, 32'h0);
    reg_check("R13 status", 6'h23, 32'h0);
    reg_check("R13 rx word0", 6'h00, 32'h0);
    observe("R13 sda_oe", 32'(0), 32'(sda_oe));
    observe("R13 scl_oe", 32'(0), 32'(scl_oe));
    observe("R13 irq", 32'(0), 32'(irq));

    bus_write(6'h22, 32'h7);
    reg_check("R10 enable readback", 6'h22, 32'h7);

    // write transaction, five bytes
    i2c_start();
    wr_byte(8'hA0, ak); observe("R1 own address ack", 32'(1), 32'(ak));
    wr_byte(8'h11, ak); observe("R4 data ack", 32'(1), 32'(ak));
    wr_byte(8'h22, ak); observe("R4 data ack", 32'(1), 32'(ak));
    wr_byte(8'h33, ak); observe("R4 data ack", 32'(1), 32'(ak));
    wr_byte(8'h44, ak); observe("R4 data ack", 32'(1), 32'(ak));
    wr_byte(8'h55, ak); observe("R4 data ack", 32'(1), 32'(ak));
    i2c_stop();
    reg_check("R3 wr_ptr after 5 bytes", 6'h20, 32'd5);
    reg_check("R2 rx word0 lanes", 6'h00, 32'h44332211);
    reg_check("R2 rx word1 lanes", 6'h01, 32'h00000055);
    reg_check("R9 write end on stop", 6'h23, 32'h4);
    observe("R10 irq with enable", 32'(1), 32'(irq));

    bus_write(6'h23, 32'h4);
    reg_check("R11 status cleared", 6'h23, 32'h0);
    observe("R10 irq low after clear", 32'(0), 32'(irq));

    // foreign address
    i2c_start();
    wr_byte(8'hA2, ak); observe("R1 foreign address nack", 32'(0), 32'(ak));
    wr_byte(8'h99, ak); observe("R1 foreign data nack", 32'(0), 32'(ak));
    i2c_stop();
    reg_check("R1 wr_ptr unchanged", 6'h20, 32'd5);
    reg_check("R1 status unchanged", 6'h23, 32'h0);
    reg_check("R1 rx word1 unchanged", 6'h01, 32'h00000055);

    // read transaction
    bus_write(6'h10, 32'h5AC30F81);
    bus_write(6'h11, 32'h000000E7);
    reg_check("R5 tx word readback", 6'h10, 32'h5AC30F81);
    i2c_start();
    wr_byte(8'hA1, ak); observe("R1 read address ack", 32'(1), 32'(ak));
    rd_byte(1'b1, d); observe("R5 read byte0", 32'h81, 32'(d));
    reg_check("R6 rd_ptr mid transfer", 6'h21, 32'd8);
    rd_byte(1'b1, d); observe("R7 ack continues", 32'h0F, 32'(d));
    rd_byte(1'b0, d); observe("R5 read byte2", 32'hC3, 32'(d));
    observe("R7 sda released after nack", 32'(0), 32'(sda_oe));
    i2c_stop();
    reg_check("R6 rd_ptr in bits", 6'h21, 32'd24);
    reg_check("R8 R7 read start and end", 6'h23, 32'h3);
    bus_write(6'h23, 32'h7);

    // write then repeated start into read
    i2c_start();
    wr_byte(8'hA0, ak); observe("R1 address ack", 32'(1), 32'(ak));
    wr_byte(8'h66, ak); observe("R4 data ack", 32'(1), 32'(ak));
    i2c_start();
    reg_check("R9 write end on repeated start", 6'h23, 32'h4);
    wr_byte(8'hA1, ak); observe("R1 address ack", 32'(1), 32'(ak));
    rd_byte(1'b0, d); observe("R5 byte at pointer 3", 32'h5A, 32'(d));
    i2c_stop();
    reg_check("R9 R8 R7 all status", 6'h23, 32'h7);
    reg_check("R2 rx word1 after append", 6'h01, 32'h00006655);
    reg_check("R6 rd_ptr continued", 6'h21, 32'd32);

    // pointer clears
    bus_write(6'h20, 32'hFFFF_FFFF);
    bus_write(6'h21, 32'h0);
    reg_check("R12 wr_ptr cleared", 6'h20, 32'd0);
    reg_check("R12 rd_ptr cleared", 6'h21, 32'd0);
    i2c_start();
    wr_byte(8'hA1, ak);
    rd_byte(1'b0, d); observe("R12 read restarts at byte 0", 32'h81, 32'(d));
    i2c_stop();

    // wrap of the write pointer
    bus_write(6'h23, 32'h7);
    reg_check("R11 status all cleared", 6'h23, 32'h0);
    i2c_start();
    wr_byte(8'hA0, ak);
    nak = 0;
    for (int i = 0; i < 66; i++) begin
      wr_byte(8'(i), ak);
      if (!ak) nak++;
    end
    i2c_stop();
    observe("R4 no nack in long write", 32'(0), 32'(nak));
    reg_check("R3 wr_ptr wrapped", 6'h20, 32'd2);
    reg_check("R3 rx word0 overwritten", 6'h00, 32'h03024140);
    reg_check("R2 rx word15", 6'h0F, 32'h3F3E3D3C);

    // enable masking
    bus_write(6'h22, 32'h3);
    observe("R10 masked status", 32'(0), 32'(irq));
    reg_check("R10 status still set", 6'h23, 32'h4);
    bus_write(6'h22, 32'h4);
    observe("R10 unmasked status", 32'(1), 32'(irq));
    bus_write(6'h23, 32'h3);
    reg_check("R11 zero-written bit kept", 6'h23, 32'h4);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule